// File: doc/BRIEF.md
# Regulator Fault Protection Latch

This block decides, for a single-phase buck regulator, when the gate drivers must be overridden and when the converter must shut itself down until it is re-enabled. All of its inputs are already-digitised comparator outputs and flags, sampled on one clock. It sees supply undervoltage on each rail, a relative core overvoltage (above 114 % of target), an absolute core overvoltage (above 2.0 V), one current-limit pulse per switching cycle, a core-below-window flag, over-temperature, soft-start completion, a voltage-transition flag and enable.

Each fault has its own rule. A fault may or may not latch. It may be armed at all times or only in some phases. It forces one of four driver states: no override, both gates low, low-side gate forced on, or high-side gate forced off. A latched fault holds until enable goes low or a supply drops, and the analog soft-start capacitor may be discharged only then. Sustained current limiting with the core below its window is counted over a parameterised number of pulses (32 by default) before the part latches off.

Top module: `power_fault_latch`

## Requirements
- R1: During and right after reset, with no faults present, the driver override is 0 (none) and the latched-fault flag is low.
- R2: While any rail undervoltage input is high, the override is 1 (both gates low) in the same cycle. Undervoltage does not latch: once it clears, the override returns to 0 if no other fault is latched.
- R3: The relative overvoltage input latches the override to 2 (low-side on) at the next clock edge. It does so only while soft-start is done and no transition is in progress; otherwise it has no effect.
- R4: The absolute overvoltage input latches the override to 2 at the next clock edge in any phase, including transitions and soft-start.
- R5: The 32nd current-limit pulse in a row that arrives while the core is below the window and soft-start is done latches the override to 3 (high-side off) at that clock edge. Fewer pulses latch nothing.
- R6: The current-limit pulse count returns to zero on any cycle where the core is inside the window or soft-start is not done.
- R7: The over-temperature input latches the override to 1 (both gates low) at the next clock edge.
- R8: When several faults are latched, the override picks over-temperature (1) first, then overvoltage (2), then current limit (3).
- R9: Enable low or any undervoltage clears every latched fault and the pulse count at the next edge, and blocks new latching while it lasts. Otherwise a latched fault persists.
- R10: The soft-start discharge request is high exactly while enable is low or any undervoltage is present.
- R11: The latched-fault flag is high exactly while at least one fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| uv_i | input | 2 | Undervoltage flag per supply rail (N_RAILS) |
| ov_rel_i | input | 1 | Core above 114 % of target |
| ov_abs_i | input | 1 | Core above absolute 2.0 V level |
| cl_pulse_i | input | 1 | One-cycle current-limit event |
| below_win_i | input | 1 | Core below the power-good window |
| ot_i | input | 1 | Over-temperature |
| ss_done_i | input | 1 | Soft-start finished |
| trans_i | input | 1 | Voltage or sleep transition in progress |
| drv_ovr_o | output | 2 | Driver override: 0 none, 1 both low, 2 low-side on, 3 high-side off |
| fault_latched_o | output | 1 | At least one fault is latched |
| ss_dis_o | output | 1 | Discharge the soft-start capacitor |

## Verification
The hardest state to reach from the ports is the current-limit latch. It needs 32 uninterrupted pulses while the core is below the window, soft-start is done, enable is high and both supplies are good. Random stimulus almost never holds all of that long enough. Directed sequences therefore drive runs of 31 pulses, break them with one in-window cycle or a soft-start drop, and then complete the run to 32. Random mixes are layered on top to cover priority and clearing, and every cycle is compared against a bench model of the latches.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [1:0] {
    DRV_NONE    = 2'd0,
    DRV_ALL_OFF = 2'd1,
    DRV_LS_ON   = 2'd2,
    DRV_HS_OFF  = 2'd3
  } drv_ovr_e;

  localparam int unsigned NUM_LATCH = 3;
  localparam int unsigned IDX_OT = 0;
  localparam int unsigned IDX_OV = 1;
  localparam int unsigned IDX_CL = 2;
endpackage

// File: rtl/pfl_qualify.sv
module pfl_qualify #(
  parameter int unsigned N_RAILS = 2
) (
  input  logic               en_i,
  input  logic [N_RAILS-1:0] uv_i,
  input  logic               ov_rel_i,
  input  logic               ov_abs_i,
  input  logic               ot_i,
  input  logic               below_win_i,
  input  logic               ss_done_i,
  input  logic               trans_i,
  output logic               uv_o,
  output logic               clear_o,
  output logic               ov_trip_o,
  output logic               ot_trip_o,
  output logic               cl_armed_o
);
  assign uv_o       = |uv_i;
  assign clear_o    = !en_i || uv_o;
  // relative OV only in steady state; absolute OV always armed
  assign ov_trip_o  = ov_abs_i || (ov_rel_i && ss_done_i && !trans_i);
  assign ot_trip_o  = ot_i;
  assign cl_armed_o = below_win_i && ss_done_i;
endmodule

// File: rtl/pfl_cl_count.sv
module pfl_cl_count #(
  parameter int unsigned PULSES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic armed_i,
  input  logic pulse_i,
  output logic trip_o
);
  localparam int unsigned CW = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

  logic [CW-1:0] cnt_q;

  assign trip_o = !clear_i && armed_i && pulse_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || !armed_i) cnt_q <= '0;
    else if (trip_o)              cnt_q <= '0;
    else if (pulse_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pfl_latch_bank.sv
module pfl_latch_bank
  import pfl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic [NUM_LATCH-1:0] set_i,
  output logic [NUM_LATCH-1:0] lat_o
);
  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_o[g] <= 1'b0;
      else if (clear_i)  lat_o[g] <= 1'b0;   // clear dominates set
      else if (set_i[g]) lat_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pfl_drv_arbiter.sv
module pfl_drv_arbiter
  import pfl_pkg::*;
(
  input  logic                 uv_i,
  input  logic [NUM_LATCH-1:0] lat_i,
  output drv_ovr_e             drv_o,
  output logic                 any_o
);
  assign any_o = |lat_i;

  always_comb begin
    if (uv_i || lat_i[IDX_OT]) drv_o = DRV_ALL_OFF;
    else if (lat_i[IDX_OV])    drv_o = DRV_LS_ON;
    else if (lat_i[IDX_CL])    drv_o = DRV_HS_OFF;
    else                       drv_o = DRV_NONE;
  end
endmodule

// File: rtl/power_fault_latch.sv
module power_fault_latch
  import pfl_pkg::*;
#(
  parameter int unsigned N_RAILS   = 2,
  parameter int unsigned CL_PULSES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_RAILS-1:0] uv_i,
  input  logic               ov_rel_i,
  input  logic               ov_abs_i,
  input  logic               cl_pulse_i,
  input  logic               below_win_i,
  input  logic               ot_i,
  input  logic               ss_done_i,
  input  logic               trans_i,
  output logic [1:0]         drv_ovr_o,
  output logic               fault_latched_o,
  output logic               ss_dis_o
);
  logic uv, clear, ov_trip, ot_trip, cl_armed, cl_trip;
  logic [NUM_LATCH-1:0] set_v, lat_v;
  drv_ovr_e drv;

  pfl_qualify #(.N_RAILS(N_RAILS)) u_qual (
    .en_i        (en_i),
    .uv_i        (uv_i),
    .ov_rel_i    (ov_rel_i),
    .ov_abs_i    (ov_abs_i),
    .ot_i        (ot_i),
    .below_win_i (below_win_i),
    .ss_done_i   (ss_done_i),
    .trans_i     (trans_i),
    .uv_o        (uv),
    .clear_o     (clear),
    .ov_trip_o   (ov_trip),
    .ot_trip_o   (ot_trip),
    .cl_armed_o  (cl_armed)
  );

  pfl_cl_count #(.PULSES(CL_PULSES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .armed_i (cl_armed),
    .pulse_i (cl_pulse_i),
    .trip_o  (cl_trip)
  );

  always_comb begin
    set_v         = '0;
    set_v[IDX_OT] = ot_trip;
    set_v[IDX_OV] = ov_trip;
    set_v[IDX_CL] = cl_trip;
  end

  pfl_latch_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .set_i   (set_v),
    .lat_o   (lat_v)
  );

  pfl_drv_arbiter u_arb (
    .uv_i  (uv),
    .lat_i (lat_v),
    .drv_o (drv),
    .any_o (fault_latched_o)
  );

  assign drv_ovr_o = drv;
  assign ss_dis_o  = clear;
endmodule

// File: rtl/power_fault_latch_chk.sv
module power_fault_latch_chk #(
  parameter int unsigned N_RAILS = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [N_RAILS-1:0] uv_i,
  input logic               ov_abs_i,
  input logic               ot_i,
  input logic [1:0]         drv_ovr_o,
  input logic               fault_latched_o,
  input logic               ss_dis_o
);
  // R2
  uv_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_i) |-> (drv_ovr_o == 2'd1));
  // R4
  abs_ov_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(|uv_i) && ov_abs_i) |=> fault_latched_o);
  // R7
  ot_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(|uv_i) && ot_i) |=> (drv_ovr_o == 2'd1));
  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_dis_o |=> !fault_latched_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_latched_o && en_i && !(|uv_i)) |=> fault_latched_o);
  // R11
  flag_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_latched_o |-> (drv_ovr_o != 2'd0));
endmodule

bind power_fault_latch power_fault_latch_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .uv_i            (uv_i),
  .ov_abs_i        (ov_abs_i),
  .ot_i            (ot_i),
  .drv_ovr_o       (drv_ovr_o),
  .fault_latched_o (fault_latched_o),
  .ss_dis_o        (ss_dis_o)
);

// File: tb/power_fault_latch_test.sv
`timescale 1ns/1ps
module power_fault_latch_test;
  localparam int PULSES = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ov_rel = 0, ov_abs = 0, pulse = 0, below = 0, ot = 0, ss_done = 0, trans = 0;
  logic [1:0] uv = 2'b00;
  logic [1:0] drv;
  logic latched, ss_dis;

  int n_tests = 0, n_fail = 0;
  bit m_ot = 0, m_ov = 0, m_cl = 0;
  int m_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  power_fault_latch uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uv_i(uv), .ov_rel_i(ov_rel),
    .ov_abs_i(ov_abs), .cl_pulse_i(pulse), .below_win_i(below), .ot_i(ot),
    .ss_done_i(ss_done), .trans_i(trans), .drv_ovr_o(drv),
    .fault_latched_o(latched), .ss_dis_o(ss_dis)
  );

  function automatic int exp_drv();
    if (|uv || m_ot) return 1;
    if (m_ov) return 2;
    if (m_cl) return 3;
    return 0;
  endfunction

  task automatic model_step();
    if (!en || |uv) begin
      m_ot = 0; m_ov = 0; m_cl = 0; m_cnt = 0;
    end else begin
      if (ot) m_ot = 1;
      if (ov_abs || (ov_rel && ss_done && !trans)) m_ov = 1;
      if (!(below && ss_done)) m_cnt = 0;
      else if (pulse) begin
        if (m_cnt == PULSES - 1) begin m_cl = 1; m_cnt = 0; end
        else m_cnt++;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(drv == 2'(exp_drv()), tag, drv, exp_drv());
    chk(ss_dis == (!en || |uv), "R10 discharge", ss_dis, int'(!en || |uv));
    chk(latched == (m_ot | m_ov | m_cl), "R11 latched flag", latched, int'(m_ot | m_ov | m_cl));
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    #1;
    compare_all(tag);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    ov_rel = 0; ov_abs = 0; pulse = 0; ot = 0; uv = 0; trans = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    #12;
    chk(drv == 2'd0, "R1 reset drv", drv, 0);
    chk(latched == 1'b0, "R1 reset flag", latched, 0);
    chk(ss_dis == 1'b1, "R10 en low in reset", ss_dis, 1);
    @(negedge clk);
    rst_n = 1;
    en = 1;
    tick("R1 after reset");
    chk(drv == 2'd0, "R1 idle drv", drv, 0);

    // R6: pulses during soft-start do not count
    below = 1; ss_done = 0; pulse = 1;
    for (int i = 0; i < 40; i++) tick("R6 soft-start inhibit");
    chk(drv == 2'd0, "R6 no latch in soft-start", drv, 0);

    // R5: 31 pulses, then in-window break, then full run
    ss_done = 1;
    for (int i = 0; i < 31; i++) tick("R5 31 pulses");
    chk(drv == 2'd0, "R5 31 pulses no latch", drv, 0);
    below = 0; tick("R6 window reset");
    below = 1;
    for (int i = 0; i < 31; i++) tick("R6 restart count");
    chk(drv == 2'd0, "R6 count restarted", drv, 0);
    tick("R5 32nd pulse");
    chk(drv == 2'd3, "R5 current-limit latch", drv, 3);
    pulse = 0; below = 0;

    // R8 priority
    ov_rel = 1; tick("R8 ov over cl");
    chk(drv == 2'd2, "R8 ov over cl", drv, 2);
    ov_rel = 0; ot = 1; tick("R8 ot over ov");
    chk(drv == 2'd1, "R8 ot over ov", drv, 1);
    ot = 0;

    // R9 clear by enable
    en = 0; tick("R9 en low");
    chk(latched == 1'b0, "R9 cleared by en", latched, 0);
    ot = 1; tick("R9 no latch while disabled");
    chk(latched == 1'b0, "R9 blocked while disabled", latched, 0);
    ot = 0; en = 1; tick("R9 re-enable");
    chk(drv == 2'd0, "R9 clean after re-enable", drv, 0);

    // R3 relative OV ignored during transition / soft-start
    trans = 1; ov_rel = 1;
    for (int i = 0; i < 5; i++) tick("R3 ignored in transition");
    chk(drv == 2'd0, "R3 ignored in transition", drv, 0);
    trans = 0; ss_done = 0;
    for (int i = 0; i < 5; i++) tick("R3 ignored in soft-start");
    chk(drv == 2'd0, "R3 ignored in soft-start", drv, 0);
    ss_done = 1; tick("R3 latch steady");
    chk(drv == 2'd2, "R3 relative ov latch", drv, 2);
    ov_rel = 0;

    // R2 undervoltage clears and is not latched
    uv = 2'b01; #1;
    chk(drv == 2'd1, "R2 uv same cycle", drv, 1);
    tick("R2 uv rail a");
    uv = 2'b00; tick("R2 uv gone");
    chk(drv == 2'd0, "R2 not latched", drv, 0);

    // R4 absolute OV during transition and soft-start
    trans = 1; ss_done = 0; ov_abs = 1; tick("R4 abs ov");
    chk(drv == 2'd2, "R4 abs ov in transition", drv, 2);
    ov_abs = 0; trans = 0; ss_done = 1;
    uv = 2'b10; tick("R2 uv rail b");
    chk(drv == 2'd1, "R2 uv rail b", drv, 1);
    uv = 2'b00; tick("R9 cleared by uv");
    chk(latched == 1'b0, "R9 cleared by uv", latched, 0);

    // R7 over-temperature
    ot = 1; tick("R7 ot"); ot = 0;
    chk(drv == 2'd1, "R7 ot latch", drv, 1);
    tick("R7 ot held");
    en = 0; tick("R9 clear"); en = 1;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      en      = ($urandom_range(99) >= 3);
      uv[0]   = ($urandom_range(99) < 2);
      uv[1]   = ($urandom_range(99) < 2);
      ov_rel  = ($urandom_range(99) < 2);
      ov_abs  = ($urandom_range(199) < 1);
      ot      = ($urandom_range(199) < 1);
      pulse   = ($urandom_range(99) < 60);
      below   = ($urandom_range(99) < 95);
      ss_done = ($urandom_range(99) < 97);
      trans   = ($urandom_range(99) < 20);
      tick("R8 random mix");
    end
    clear_inputs();
    tick("R8 random tail");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule